// File: doc/BRIEF.md
# Flash Program/Erase Controller Front End

This block sits behind a simple 32-bit bus slave port and owns a small internal nonvolatile-style array. Software unlocks it with a two-word key sequence, selects program mode or one of two erase modes in a control register, and follows progress through a status register. In program mode, each correctly sized half-word store into the array window starts one timed program cycle. A page erase fills one 1 KB page with all ones. A mass erase does the same for every page that is not write-protected.

Each operation holds a busy flag for a fixed, parameterised number of cycles. When it finishes, busy drops and an end-of-operation flag rises. While busy is set, every register write and every array write is discarded. Array stores of the wrong width or at an odd address get a bus error response. Operations aimed at a protected page are refused and raise a write-protect error flag. Both status flags stay set until software clears them by writing ones.

Top module: `flashc_top`

## Requirements
- R1: After reset the controller is locked, no mode bit is set, and busy, end-of-operation and write-protect error all read 0.
- R2: Writing KEY_A and then KEY_B to the key register clears the lock. A wrong value or a wrong order leaves it locked until reset. A control write with bit 7 set relocks at once and clears all mode bits.
- R3: While the controller is locked, control register writes have no effect, so program mode cannot be entered.
- R4: In program mode, a half-word store (data in bits 15:0) to an even array address sets busy for exactly PROG_CYCLES cycles after the store cycle. Busy then reads 0, end-of-operation reads 1, and the half-word reads back.
- R5: In program mode, an array store whose size is not half-word, or whose address is odd, returns busErr=1 in the response cycle. It starts no operation and leaves the array unchanged.
- R6: With program mode off, array stores of any size change nothing and return no bus error.
- R7: While busy reads 1, writes to the control, status, key and erase-address registers and to the array are ignored. This includes a write landing on the very cycle the operation finishes.
- R8: A control write with page-erase (bit 1) and start (bit 3) sets busy for ERASE_CYCLES cycles. The page holding the erase address then reads all ones, and end-of-operation reads 1.
- R9: A control write with mass-erase (bit 2) and start (bit 3) sets busy for PAGES*ERASE_CYCLES cycles. Every unprotected page then reads all ones and protected pages are left untouched.
- R10: A program store or page erase aimed at a page whose PROT_MASK bit is 1 changes nothing, never sets busy, and sets the write-protect error flag.
- R11: Status flags are write-1-to-clear: data bit 1 clears end-of-operation and bit 2 clears write-protect error. Writing 0 to a flag leaves it set.
- R12: Register map, each at byte offset from 0x8000: key +0x0, control +0x4, status +0x8, erase address +0xC. Control reads lock in bit 7 and program, page-erase and mass-erase in bits 0..2. Status reads busy in bit 0, end-of-operation in bit 1 and write-protect error in bit 2. Array bytes occupy 0x0000 up to PAGES*PAGE_BYTES, and array reads return the half-word in bits 15:0. Read data and busErr appear one cycle after the request. Size codes are 0 byte, 1 half-word, 2 word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Request valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | AW | Byte address |
| busSize | input | 2 | Access size code |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, one cycle after the request |
| busErr | output | 1 | Bus error response, one cycle after the request |

## Verification
The sharp overlap is a software status write falling on the same clock edge where a running program operation completes. At that edge busy is still 1 when the write is sampled, so the write must be dropped and end-of-operation must survive. The bench issues a program store, counts the busy cycles, and places a clear-end-of-operation write exactly PROG_CYCLES cycles after the store. It then expects the status register to read busy 0 and end-of-operation 1, and a second clear to take effect.

// File: rtl/flashc_pkg.sv
package flashc_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2
  } opState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic progLatch;   // capture target index and data
    logic progCommit;  // write captured half-word into the array
    logic eraseLoad;   // load erase pointer
    logic eraseMass;   // pointer starts at 0 instead of selected page
    logic eraseAdv;    // advance erase pointer
    logic eraseWe;     // write erased value at pointer
  } dpStrobe_t;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam logic [1:0] RS_KEY   = 2'd0;
  localparam logic [1:0] RS_CTRL  = 2'd1;
  localparam logic [1:0] RS_STAT  = 2'd2;
  localparam logic [1:0] RS_EADDR = 2'd3;

  localparam int CB_PROG  = 0;
  localparam int CB_PER   = 1;
  localparam int CB_MER   = 2;
  localparam int CB_START = 3;
  localparam int CB_LOCK  = 7;

  localparam int SB_BUSY = 0;
  localparam int SB_EOP  = 1;
  localparam int SB_WPE  = 2;

endpackage

// File: rtl/flashc_dp.sv
module flashc_dp
  import flashc_pkg::*;
#(
  parameter int PAGE_BYTES = 1024,
  parameter int PAGES      = 2,
  localparam int HW_N   = PAGE_BYTES * PAGES / 2,
  localparam int HW_AW  = $clog2(HW_N),
  localparam int PHW_AW = $clog2(PAGE_BYTES / 2),
  localparam int PG_W   = (PAGES > 1) ? $clog2(PAGES) : 1
) (
  input  logic              clk,
  input  dpStrobe_t         strb,
  input  logic [HW_AW-1:0]  reqIdx,
  input  logic [15:0]       reqData,
  input  logic [PG_W-1:0]   erasePage,
  input  logic [HW_AW-1:0]  rdIdx,
  output logic [15:0]       rdHalf
);

  logic [15:0]      mem [HW_N];
  logic [HW_AW-1:0] progIdx;
  logic [15:0]      progData;
  logic [HW_AW-1:0] erasePtr;

  always_ff @(posedge clk) begin
    if (strb.progLatch) begin
      progIdx  <= reqIdx;
      progData <= reqData;
    end
    if (strb.progCommit) mem[progIdx] <= progData;
    if (strb.eraseLoad) begin
      erasePtr <= strb.eraseMass ? '0 : (HW_AW'(erasePage) << PHW_AW);
    end else if (strb.eraseAdv) begin
      erasePtr <= erasePtr + 1'b1;
    end
    if (strb.eraseWe) mem[erasePtr] <= 16'hFFFF;
  end

  assign rdHalf = mem[rdIdx];

endmodule

// File: rtl/flashc_ctrl.sv
module flashc_ctrl
  import flashc_pkg::*;
#(
  parameter int          AW           = 16,
  parameter int          PAGE_BYTES   = 1024,
  parameter int          PAGES        = 2,
  parameter int          PROG_CYCLES  = 8,
  parameter int          ERASE_CYCLES = 600,
  parameter logic [PAGES-1:0] PROT_MASK = 2'b10,
  parameter logic [31:0] KEY_A        = 32'hC0DE_1357,
  parameter logic [31:0] KEY_B        = 32'h2468_ACE0,
  localparam int PG_W = (PAGES > 1) ? $clog2(PAGES) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            busValid,
  input  logic            busWrite,
  input  logic [AW-1:0]   busAddr,
  input  logic [1:0]      busSize,
  input  logic [31:0]     busWdata,
  output logic [31:0]     busRdata,
  output logic            busErr,
  input  logic [15:0]     arrHalf,
  output dpStrobe_t       strb,
  output logic [PG_W-1:0] erasePage,
  output logic            busyMon,
  output logic            eopMon,
  output logic            lockMon,
  output logic            progEnMon
);

  localparam int ARRAY_BYTES = PAGE_BYTES * PAGES;
  localparam int PB_AW       = $clog2(PAGE_BYTES);
  localparam int PAGE_HW     = PAGE_BYTES / 2;
  localparam int MAX_CYC     = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int CNT_W       = $clog2(MAX_CYC + 1);
  localparam int STEP_W      = $clog2(PAGE_HW + 1);

  typedef enum logic [1:0] {K_WAIT_A, K_WAIT_B, K_DEAD} keyStage_t;

  opState_t         state;
  keyStage_t        keyStage;
  logic             lock, progEn, perEn, merEn, eop, wpErr;
  logic [AW-1:0]    eraseAddr;
  logic [CNT_W-1:0] opCnt;
  logic [STEP_W-1:0] stepCnt;
  logic [PG_W-1:0]  curPage, pagesLeft;

  logic busy, wrAny, isArr, isReg, regWr;
  logic keyWr, ctrlWr, statWr, eaWr, ctrlOpen;
  logic eraseReq, eraseBlk, eraseGo;
  logic arrWr, sizeBad, progReq, progBlk, progGo, stepOn;
  logic [1:0]       regSel;
  logic [PG_W-1:0]  reqPage, eaPage;
  logic [31:0]      rdVal;

  // ---- decode
  assign busy    = (state != OP_IDLE);
  assign wrAny   = busValid && busWrite;
  assign isArr   = busAddr < AW'(ARRAY_BYTES);
  assign isReg   = busAddr[AW-1] && (busAddr[AW-2:4] == '0);
  assign regSel  = busAddr[3:2];
  assign regWr   = wrAny && isReg && !busy;
  assign keyWr   = regWr && (regSel == RS_KEY);
  assign ctrlWr  = regWr && (regSel == RS_CTRL);
  assign statWr  = regWr && (regSel == RS_STAT);
  assign eaWr    = regWr && (regSel == RS_EADDR);
  assign reqPage = busAddr[PB_AW +: PG_W];
  assign eaPage  = eraseAddr[PB_AW +: PG_W];

  assign ctrlOpen = ctrlWr && !lock && !busWdata[CB_LOCK];
  assign eraseReq = ctrlOpen && busWdata[CB_START] && (busWdata[CB_MER] || busWdata[CB_PER]);
  assign eraseBlk = eraseReq && !busWdata[CB_MER] && PROT_MASK[eaPage];
  assign eraseGo  = eraseReq && !eraseBlk;

  assign arrWr    = wrAny && isArr && progEn;
  assign sizeBad  = (busSize != SZ_HALF) || busAddr[0];
  assign progReq  = arrWr && !sizeBad && !busy;
  assign progBlk  = progReq && PROT_MASK[reqPage];
  assign progGo   = progReq && !progBlk;

  assign stepOn   = (state == OP_ERASE) && (stepCnt < STEP_W'(PAGE_HW));

  // ---- strobes to datapath
  always_comb begin
    strb            = '0;
    strb.progLatch  = progGo;
    strb.progCommit = (state == OP_PROG) && (opCnt == '0);
    strb.eraseLoad  = eraseGo;
    strb.eraseMass  = busWdata[CB_MER];
    strb.eraseAdv   = stepOn;
    strb.eraseWe    = stepOn && !PROT_MASK[curPage];
  end
  assign erasePage = eaPage;

  // ---- read mux
  always_comb begin
    rdVal = '0;
    if (isArr) begin
      rdVal = {16'h0, arrHalf};
    end else if (isReg) begin
      case (regSel)
        RS_CTRL:  rdVal = {24'h0, lock, 4'h0, merEn, perEn, progEn};
        RS_STAT:  rdVal = {29'h0, wpErr, eop, busy};
        RS_EADDR: rdVal = 32'(eraseAddr);
        default:  rdVal = '0;
      endcase
    end
  end

  // ---- state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= OP_IDLE;
      keyStage  <= K_WAIT_A;
      lock      <= 1'b1;
      progEn    <= 1'b0;
      perEn     <= 1'b0;
      merEn     <= 1'b0;
      eop       <= 1'b0;
      wpErr     <= 1'b0;
      eraseAddr <= '0;
      opCnt     <= '0;
      stepCnt   <= '0;
      curPage   <= '0;
      pagesLeft <= '0;
      busRdata  <= '0;
      busErr    <= 1'b0;
    end else begin
      busErr   <= arrWr && sizeBad;
      busRdata <= (busValid && !busWrite) ? rdVal : '0;

      if (keyWr && lock) begin
        case (keyStage)
          K_WAIT_A: keyStage <= (busWdata == KEY_A) ? K_WAIT_B : K_DEAD;
          K_WAIT_B: begin
            if (busWdata == KEY_B) begin
              lock     <= 1'b0;
              keyStage <= K_WAIT_A;
            end else begin
              keyStage <= K_DEAD;
            end
          end
          default: keyStage <= K_DEAD;
        endcase
      end

      if (ctrlWr && !lock) begin
        if (busWdata[CB_LOCK]) begin
          lock   <= 1'b1;
          progEn <= 1'b0;
          perEn  <= 1'b0;
          merEn  <= 1'b0;
        end else begin
          progEn <= busWdata[CB_PROG];
          perEn  <= busWdata[CB_PER];
          merEn  <= busWdata[CB_MER];
        end
      end

      if (eaWr) eraseAddr <= busWdata[AW-1:0];

      if (statWr && busWdata[SB_EOP]) eop   <= 1'b0;
      if (statWr && busWdata[SB_WPE]) wpErr <= 1'b0;
      if (progBlk || eraseBlk)        wpErr <= 1'b1;

      case (state)
        OP_IDLE: begin
          if (progGo) begin
            state <= OP_PROG;
            opCnt <= CNT_W'(PROG_CYCLES - 1);
          end else if (eraseGo) begin
            state     <= OP_ERASE;
            opCnt     <= CNT_W'(ERASE_CYCLES - 1);
            stepCnt   <= '0;
            curPage   <= busWdata[CB_MER] ? '0 : eaPage;
            pagesLeft <= busWdata[CB_MER] ? PG_W'(PAGES - 1) : '0;
          end
        end
        OP_PROG: begin
          if (opCnt == '0) begin
            state <= OP_IDLE;
            eop   <= 1'b1;
          end else begin
            opCnt <= opCnt - 1'b1;
          end
        end
        OP_ERASE: begin
          if (stepOn) stepCnt <= stepCnt + 1'b1;
          if (opCnt == '0) begin
            if (pagesLeft == '0) begin
              state <= OP_IDLE;
              eop   <= 1'b1;
            end else begin
              pagesLeft <= pagesLeft - 1'b1;
              curPage   <= curPage + 1'b1;
              opCnt     <= CNT_W'(ERASE_CYCLES - 1);
              stepCnt   <= '0;
            end
          end else begin
            opCnt <= opCnt - 1'b1;
          end
        end
        default: state <= OP_IDLE;
      endcase
    end
  end

  assign busyMon   = busy;
  assign eopMon    = eop;
  assign lockMon   = lock;
  assign progEnMon = progEn;

endmodule

// File: rtl/flashc_top.sv
module flashc_top
  import flashc_pkg::*;
#(
  parameter int          AW           = 16,
  parameter int          PAGE_BYTES   = 1024,
  parameter int          PAGES        = 2,
  parameter int          PROG_CYCLES  = 8,
  parameter int          ERASE_CYCLES = 600,
  parameter logic [PAGES-1:0] PROT_MASK = 2'b10,
  parameter logic [31:0] KEY_A        = 32'hC0DE_1357,
  parameter logic [31:0] KEY_B        = 32'h2468_ACE0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busValid,
  input  logic          busWrite,
  input  logic [AW-1:0] busAddr,
  input  logic [1:0]    busSize,
  input  logic [31:0]   busWdata,
  output logic [31:0]   busRdata,
  output logic          busErr
);

  localparam int HW_AW = $clog2(PAGE_BYTES * PAGES / 2);
  localparam int PG_W  = (PAGES > 1) ? $clog2(PAGES) : 1;

  dpStrobe_t       strb;
  logic [PG_W-1:0] erasePage;
  logic [15:0]     arrHalf;
  logic            busyMon, eopMon, lockMon, progEnMon;

  flashc_ctrl #(
    .AW(AW), .PAGE_BYTES(PAGE_BYTES), .PAGES(PAGES),
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES),
    .PROT_MASK(PROT_MASK), .KEY_A(KEY_A), .KEY_B(KEY_B)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busSize(busSize), .busWdata(busWdata),
    .busRdata(busRdata), .busErr(busErr),
    .arrHalf(arrHalf), .strb(strb), .erasePage(erasePage),
    .busyMon(busyMon), .eopMon(eopMon), .lockMon(lockMon), .progEnMon(progEnMon)
  );

  flashc_dp #(
    .PAGE_BYTES(PAGE_BYTES), .PAGES(PAGES)
  ) u_dp (
    .clk(clk), .strb(strb),
    .reqIdx(busAddr[HW_AW:1]), .reqData(busWdata[15:0]),
    .erasePage(erasePage),
    .rdIdx(busAddr[HW_AW:1]), .rdHalf(arrHalf)
  );

endmodule

// File: rtl/flashc_chk.sv
module flashc_chk
  import flashc_pkg::*;
#(
  parameter int AW          = 16,
  parameter int ARRAY_BYTES = 2048
) (
  input logic          clk,
  input logic          rstN,
  input logic          busValid,
  input logic          busWrite,
  input logic [AW-1:0] busAddr,
  input logic [1:0]    busSize,
  input logic          busErr,
  input dpStrobe_t     strb,
  input logic          busyMon,
  input logic          eopMon,
  input logic          lockMon,
  input logic          progEnMon
);

  // R5: a malformed array store in program mode gets an error response
  a_r5_bad_store_errs: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && (busAddr < AW'(ARRAY_BYTES)) && progEnMon &&
     ((busSize != SZ_HALF) || busAddr[0])) |=> busErr);

  // R6: with program mode off no write ever errors
  a_r6_no_err_prog_off: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && !progEnMon) |=> !busErr);

  // R4: dropping busy always leaves end-of-operation set
  a_r4_done_sets_eop: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyMon) |-> eopMon);

  // R4: array commit only inside a busy operation, never mixed with erase
  a_r4_commit_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    strb.progCommit |-> (busyMon && !strb.eraseWe));

  // R3: locked controller never holds program mode
  a_r3_locked_no_prog: assert property (@(posedge clk) disable iff (!rstN)
    lockMon |-> !progEnMon);

  // R7: writes during busy leave mode and lock unchanged
  a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (busyMon && busValid && busWrite) |=> ($stable(progEnMon) && $stable(lockMon)));

  // R8: erase writes only while busy
  a_r8_erase_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    strb.eraseWe |-> busyMon);

endmodule

bind flashc_top flashc_chk #(.AW(AW), .ARRAY_BYTES(PAGE_BYTES * PAGES)) u_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busSize(busSize), .busErr(busErr), .strb(strb),
  .busyMon(busyMon), .eopMon(eopMon), .lockMon(lockMon), .progEnMon(progEnMon)
);

// File: tb/tb_flashc_top.sv
module tb_flashc_top;

  localparam int          PROG   = 8;
  localparam int          ERASE  = 600;
  localparam logic [31:0] KA     = 32'hC0DE_1357;
  localparam logic [31:0] KB     = 32'h2468_ACE0;
  localparam logic [15:0] A_KEY  = 16'h8000;
  localparam logic [15:0] A_CTRL = 16'h8004;
  localparam logic [15:0] A_STAT = 16'h8008;
  localparam logic [15:0] A_EA   = 16'h800C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [15:0] busAddr = '0;
  logic [1:0]  busSize = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busErr;

  int nRun = 0, nFail = 0;
  logic [31:0] rdv;
  logic        errv;

  always #2 clk = ~clk;

  flashc_top #(
    .AW(16), .PAGE_BYTES(1024), .PAGES(2), .PROG_CYCLES(PROG),
    .ERASE_CYCLES(ERASE), .PROT_MASK(2'b10), .KEY_A(KA), .KEY_B(KB)
  ) dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .busRdata(busRdata), .busErr(busErr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus request per cycle; called at a falling edge
  task automatic busOp(input logic wr, input logic [15:0] a, input logic [1:0] sz,
                       input logic [31:0] d);
    busValid = 1'b1; busWrite = wr; busAddr = a; busSize = sz; busWdata = d;
    @(negedge clk);
    rdv = busRdata; errv = busErr;
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a);           busOp(1'b0, a, 2'd2, 32'h0); endtask
  task automatic wr32(input logic [15:0] a, input logic [31:0] d); busOp(1'b1, a, 2'd2, d); endtask
  task automatic wrH(input logic [15:0] a, input logic [15:0] d);  busOp(1'b1, a, 2'd1, {16'h0, d}); endtask

  task automatic waitIdle(output int n);
    n = 0;
    forever begin
      rd(A_STAT);
      if (!rdv[0] || n > 100000) break;
      n++;
    end
  endtask

  task automatic doReset;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic unlock;
    wr32(A_KEY, KA);
    wr32(A_KEY, KB);
  endtask

  task automatic sweepPage(input int base, output int bad);
    bad = 0;
    for (int i = 0; i < 512; i++) begin
      rd(16'(base + 2 * i));
      if (rdv[15:0] !== 16'hFFFF) bad++;
    end
  endtask

  task automatic tReset;
    rd(A_CTRL); check("R1/R12 ctrl after reset", rdv, 32'h80);
    rd(A_STAT); check("R1 status after reset", rdv, 32'h0);
  endtask

  task automatic tLocked;
    wr32(A_CTRL, 32'h1);
    rd(A_CTRL); check("R3 locked ctrl write ignored", rdv, 32'h80);
    wrH(16'h0040, 16'h1234);
    check("R6 locked array store no error", {31'h0, errv}, 32'h0);
  endtask

  task automatic tBadKey;
    wr32(A_KEY, KB);
    unlock();
    rd(A_CTRL); check("R2 wrong order stays locked", rdv, 32'h80);
    doReset();
    wr32(A_KEY, 32'h1111_2222);
    rd(A_CTRL); check("R2 wrong value stays locked", rdv, 32'h80);
    doReset();
    unlock();
    rd(A_CTRL); check("R2 correct keys unlock", rdv, 32'h0);
  endtask

  task automatic tPageErase;
    int n, bad;
    wr32(A_EA, 32'h0010);
    wr32(A_CTRL, 32'h0A);
    waitIdle(n);
    check("R8 page erase busy length", n, ERASE);
    rd(A_STAT); check("R8 eop after page erase", rdv, 32'h2);
    sweepPage(0, bad);
    check("R8 page0 all ones", bad, 0);
    wr32(A_STAT, 32'h0);
    rd(A_STAT); check("R11 writing 0 keeps eop", rdv, 32'h2);
    wr32(A_STAT, 32'h2);
    rd(A_STAT); check("R11 W1C clears eop", rdv, 32'h0);
    wr32(A_CTRL, 32'h0);
  endtask

  task automatic progOne(input logic [15:0] a, input logic [15:0] d);
    int n;
    wrH(a, d);
    check("R4 store no error", {31'h0, errv}, 32'h0);
    waitIdle(n);
    check("R4 program busy length", n, PROG);
    rd(A_STAT); check("R4 eop after program", rdv, 32'h2);
    rd(a); check("R4 readback", rdv, {16'h0, d});
    wr32(A_STAT, 32'h2);
  endtask

  task automatic tProgram;
    wr32(A_CTRL, 32'h1);
    progOne(16'h0010, 16'hA5C3);
    progOne(16'h03FE, 16'h0F0F);
    progOne(16'h0000, 16'h1234);
  endtask

  task automatic tBadSize;
    busOp(1'b1, 16'h0020, 2'd0, 32'h12);
    check("R5 byte store errors", {31'h0, errv}, 32'h1);
    busOp(1'b1, 16'h0020, 2'd2, 32'h5678);
    check("R5 word store errors", {31'h0, errv}, 32'h1);
    wrH(16'h0021, 16'h0000);
    check("R5 odd address errors", {31'h0, errv}, 32'h1);
    rd(A_STAT); check("R5 no busy after bad store", rdv, 32'h0);
    rd(16'h0020); check("R5 array unchanged", rdv, 32'hFFFF);
  endtask

  task automatic tProgOff;
    wr32(A_CTRL, 32'h0);
    wrH(16'h0030, 16'h5555);
    check("R6 half store no error", {31'h0, errv}, 32'h0);
    busOp(1'b1, 16'h0031, 2'd0, 32'h7);
    check("R6 byte store no error", {31'h0, errv}, 32'h0);
    rd(16'h0030); check("R6 array unchanged", rdv, 32'hFFFF);
  endtask

  task automatic tProtect;
    logic [15:0] snap;
    wr32(A_CTRL, 32'h1);
    rd(16'h0410); snap = rdv[15:0];
    wrH(16'h0410, ~snap);
    check("R10 protected store no error", {31'h0, errv}, 32'h0);
    rd(A_STAT); check("R10 wpErr set, no busy", rdv, 32'h4);
    rd(16'h0410); check("R10 protected data kept", rdv, {16'h0, snap});
    wr32(A_STAT, 32'h4);
    rd(A_STAT); check("R11 W1C clears wpErr", rdv, 32'h0);
    wr32(A_EA, 32'h0400);
    wr32(A_CTRL, 32'h0A);
    rd(A_STAT); check("R10 protected page erase refused", rdv, 32'h4);
    rd(16'h0410); check("R10 page erase left data", rdv, {16'h0, snap});
    wr32(A_STAT, 32'h4);
  endtask

  task automatic tBusy;
    wr32(A_CTRL, 32'h1);
    wrH(16'h0050, 16'h00FF);           // edge E0
    wr32(A_CTRL, 32'h0);               // E0+1
    wr32(A_EA, 32'h0777);              // E0+2
    wrH(16'h0052, 16'h1111);           // E0+3
    wr32(A_KEY, 32'h0);                // E0+4
    for (int i = 0; i < PROG - 5; i++) rd(A_EA);
    wr32(A_STAT, 32'h2);               // E0+PROG: completion edge, still busy
    rd(A_STAT); check("R7 clear on completion edge dropped", rdv, 32'h2);
    rd(A_CTRL); check("R7 ctrl write in busy ignored", rdv, 32'h1);
    rd(A_EA);   check("R7 erase addr write in busy ignored", rdv, 32'h0400);
    rd(16'h0052); check("R7 array store in busy ignored", rdv, 32'hFFFF);
    rd(16'h0050); check("R4 value programmed", rdv, 32'h00FF);
    wr32(A_STAT, 32'h2);
    rd(A_STAT); check("R11 later clear works", rdv, 32'h0);
  endtask

  task automatic tMass;
    logic [15:0] s0, s1, s2;
    int n, bad;
    rd(16'h0400); s0 = rdv[15:0];
    rd(16'h05FE); s1 = rdv[15:0];
    rd(16'h07FE); s2 = rdv[15:0];
    wr32(A_CTRL, 32'h0C);
    waitIdle(n);
    check("R9 mass erase busy length", n, 2 * ERASE);
    rd(A_STAT); check("R9 eop after mass erase", rdv, 32'h2);
    sweepPage(0, bad);
    check("R9 unprotected page all ones", bad, 0);
    rd(16'h0400); check("R9 protected page kept a", rdv, {16'h0, s0});
    rd(16'h05FE); check("R9 protected page kept b", rdv, {16'h0, s1});
    rd(16'h07FE); check("R9 protected page kept c", rdv, {16'h0, s2});
    wr32(A_STAT, 32'h2);
  endtask

  task automatic tRelock;
    wr32(A_CTRL, 32'h1);
    wr32(A_CTRL, 32'h81);
    rd(A_CTRL); check("R2 relock clears modes", rdv, 32'h80);
    wrH(16'h0060, 16'hBEEF);
    rd(16'h0060); check("R3 no program after relock", rdv, 32'hFFFF);
    unlock();
    rd(A_CTRL); check("R2 unlock again after relock", rdv, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tLocked();
    tBadKey();
    tPageErase();
    tProgram();
    tBadSize();
    tProgOff();
    tProtect();
    tBusy();
    tMass();
    tRelock();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule